// File: doc/BRIEF.md
# LCD Frame Timing Generator

This block produces the line and frame timing for a passive-matrix LCD column driver running at 1/160 duty. In master mode it divides the oscillator clock into a column latch strobe. It groups strobes into half frames and marks the start of each half frame with an active-low frame pulse. It also drives two level-select bits that tell the row driver which drive level to use. Those bits advance through a fixed four-step phase cycle, one step per half frame.

In slave mode the local divider stops. The block follows a strobe and frame pulse received from the master. It rebuilds the same strobe index and phase locally, so that its own level-select bits can be compared against the master's. The block also gates an active-low display-enable output. After reset or a refresh is released, that output is held off for a fixed number of frames. At any time it is forced off while the external display-off input is low.

Top module: `lcd_frame_timer`

## Requirements
- R1: In master mode (`master`=1) the strobe output repeats every `CLK_PER_STB` clocks (default 16). It is high for the first half of each period and low for the second half (default 8 and 8). The first clock after init release is the second cycle of a high phase.
- R2: A half frame is `STB_PER_HALF` strobes (default 81). In master mode `frm_n_out` is low for the whole first strobe period (strobe index 0) of every half frame and high otherwise. This gives two frame pulses per frame and a frame of 2·`STB_PER_HALF`·`CLK_PER_STB` clocks (default 2592).
- R3: Inside a half frame, `lvl2` changes value each time the strobe index advances.
- R4: The phase is 0 after init and advances by one, modulo 4, at each half-frame start. The pair (`lvl1`, `lvl2` at strobe index 0) for phases 0, 1, 2, 3 is (1,1), (1,0), (0,0), (0,1). `lvl2` at index i is that starting value XOR bit 0 of i.
- R5: In slave mode `stb_out` is held 0 and `frm_n_out` is held 1. A rising edge on `stb_in` sampled with `frm_n_in`=0 sets the strobe index to 0 and advances the phase. A rising edge with `frm_n_in`=1 advances the index, which saturates at `STB_PER_HALF`-1. A frame pulse arriving at any index realigns the index.
- R6: In slave mode, rising `stb_in` edges seen after init and before the first frame pulse change nothing (`lvl1`=1, `lvl2`=1). That first frame pulse sets phase 0 and index 0.
- R7: After init release, `blank_n` stays low until 2·`HOLD_FRAMES` half-frame starts have occurred (default 4 frames). After that it equals `disp_off_n`. In master mode this is exactly 2·`HOLD_FRAMES`·`STB_PER_HALF`·`CLK_PER_STB` clocks. In slave mode each frame pulse after the one that synchronised the block counts as one half-frame start.
- R8: While `disp_off_n` is 0, `blank_n` is 0 in the same cycle, whatever the hold state.
- R9: `rst_n`=0 or `refresh_n`=0 at a clock edge clears the divider, strobe index, phase and hold count. During init in master mode the outputs are `stb_out`=1, `frm_n_out`=0, `lvl1`=1, `lvl2`=1 and `blank_n`=0. In slave mode `stb_out` is 0 and `frm_n_out` is 1 instead.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-rate clock |
| rst_n | input | 1 | Synchronous active-low reset |
| refresh_n | input | 1 | Synchronous active-low refresh, same effect as reset on timing |
| master | input | 1 | 1 = generate timing, 0 = follow received timing |
| stb_in | input | 1 | Received strobe (slave mode) |
| frm_n_in | input | 1 | Received active-low frame pulse (slave mode) |
| disp_off_n | input | 1 | External display-off request, active low |
| stb_out | output | 1 | Generated column latch strobe |
| frm_n_out | output | 1 | Generated active-low frame pulse |
| lvl1 | output | 1 | Row-driver level select, bit 1 |
| lvl2 | output | 1 | Row-driver level select, bit 2 |
| blank_n | output | 1 | Display enable, low = display off and columns at middle level |

## Verification
Two functions can act in the same cycle: the end of the display hold and an external display-off request. The bench holds `disp_off_n` low across the clock where the hold count expires. It checks that `blank_n` stays low, then rises on the first cycle `disp_off_n` returns high. A half-frame start is also the cycle where the phase step, the `lvl2` restart and a hold-count increment all happen together. Each of these is compared every cycle against values the bench derives from the clock count since release. In slave mode, a frame pulse at the wrong strobe index provokes a realignment and a phase step in one edge, and the bench checks both.

// File: rtl/lcdt_pkg.sv
package lcdt_pkg;
   typedef logic [1:0] phase_t;

   // level-select bit 1 for a phase: high in phases 0 and 1
   function automatic logic lvl1_of(input phase_t p);
      return ~p[1];
   endfunction

   // value of level-select bit 2 at strobe index 0 of a phase
   function automatic logic lvl2_start(input phase_t p);
      return ~(p[1] ^ p[0]);
   endfunction
endpackage

// File: rtl/lcdt_clkdiv.sv
module lcdt_clkdiv #(
   parameter int CLK_PER_STB = 16
) (
   input  logic clk,
   input  logic init,
   input  logic run,
   output logic last,
   output logic stb
);
   localparam int CW   = (CLK_PER_STB > 1) ? $clog2(CLK_PER_STB) : 1;
   localparam int HALF = CLK_PER_STB / 2;

   generate
      if (CLK_PER_STB < 2 || (CLK_PER_STB % 2) != 0) begin : g_bad_cps
         $error("CLK_PER_STB must be even and at least 2");
      end
   endgenerate

   logic [CW-1:0] cnt;

   assign last = run && (cnt == CW'(CLK_PER_STB - 1));
   assign stb  = run && (cnt < CW'(HALF));

   always_ff @(posedge clk) begin
      if (init)          cnt <= '0;
      else if (run)      cnt <= last ? '0 : cnt + 1'b1;
   end

   // the strobe always falls after exactly HALF high cycles
   p_stb_fall_r1: assert property (@(posedge clk) disable iff (init)
      (run && $past(run) && $fell(stb)) |-> (cnt == CW'(HALF)));
endmodule

// File: rtl/lcdt_seq.sv
module lcdt_seq
   import lcdt_pkg::*;
#(
   parameter int STB_PER_HALF = 81
) (
   input  logic   clk,
   input  logic   init,
   input  logic   master,
   input  logic   tick,
   input  logic   stb_in,
   input  logic   frm_n_in,
   output logic [((STB_PER_HALF > 1) ? $clog2(STB_PER_HALF) : 1)-1:0] idx,
   output phase_t phase,
   output logic   hf_start
);
   localparam int IW = (STB_PER_HALF > 1) ? $clog2(STB_PER_HALF) : 1;
   localparam logic [IW-1:0] IDX_LAST = IW'(STB_PER_HALF - 1);

   generate
      if (STB_PER_HALF < 2) begin : g_bad_sph
         $error("STB_PER_HALF must be at least 2");
      end
   endgenerate

   logic stb_q, synced, rise, m_wrap, s_frame;

   assign rise     = !master && stb_in && !stb_q;
   assign m_wrap   = master && tick && (idx == IDX_LAST);
   assign s_frame  = rise && !frm_n_in;
   assign hf_start = m_wrap || (s_frame && synced);

   always_ff @(posedge clk) begin
      if (init) begin
         stb_q  <= 1'b1;
         synced <= 1'b0;
         idx    <= '0;
         phase  <= '0;
      end else begin
         stb_q <= stb_in;
         if (master) begin
            if (tick) begin
               if (m_wrap) begin
                  idx   <= '0;
                  phase <= phase + 2'd1;
               end else begin
                  idx <= idx + 1'b1;
               end
            end
         end else if (rise) begin
            if (!frm_n_in) begin
               idx    <= '0;
               synced <= 1'b1;
               phase  <= synced ? phase + 2'd1 : 2'd0;
            end else if (synced && idx != IDX_LAST) begin
               idx <= idx + 1'b1;
            end
         end
      end
   end

   p_phase_step_r4: assert property (@(posedge clk) disable iff (init)
      hf_start |=> (phase == $past(phase) + 2'd1) && (idx == '0));
   p_unsynced_still_r6: assert property (@(posedge clk) disable iff (init)
      (!master && !synced) |-> (idx == '0) && (phase == 2'd0));
endmodule

// File: rtl/lcdt_hold.sv
module lcdt_hold #(
   parameter int HOLD_FRAMES = 4
) (
   input  logic clk,
   input  logic init,
   input  logic hf_start,
   output logic done
);
   localparam int TARGET = 2 * HOLD_FRAMES;
   localparam int HW     = $clog2(TARGET + 1) + 1;

   generate
      if (HOLD_FRAMES == 0) begin : g_nohold
         assign done = 1'b1;
      end else begin : g_hold
         logic [HW-1:0] cnt;
         assign done = (cnt == HW'(TARGET));
         always_ff @(posedge clk) begin
            if (init)                  cnt <= '0;
            else if (hf_start && !done) cnt <= cnt + 1'b1;
         end
      end
   endgenerate
endmodule

// File: rtl/lcd_frame_timer.sv
module lcd_frame_timer
   import lcdt_pkg::*;
#(
   parameter int CLK_PER_STB  = 16,
   parameter int STB_PER_HALF = 81,
   parameter int HOLD_FRAMES  = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic refresh_n,
   input  logic master,
   input  logic stb_in,
   input  logic frm_n_in,
   input  logic disp_off_n,
   output logic stb_out,
   output logic frm_n_out,
   output logic lvl1,
   output logic lvl2,
   output logic blank_n
);
   localparam int IW = (STB_PER_HALF > 1) ? $clog2(STB_PER_HALF) : 1;

   logic          init, tick, hf_start, done;
   logic [IW-1:0] idx;
   phase_t        phase;

   assign init = !rst_n || !refresh_n;

   lcdt_clkdiv #(.CLK_PER_STB(CLK_PER_STB)) u_div (
      .clk(clk), .init(init), .run(master), .last(tick), .stb(stb_out));

   lcdt_seq #(.STB_PER_HALF(STB_PER_HALF)) u_seq (
      .clk(clk), .init(init), .master(master), .tick(tick),
      .stb_in(stb_in), .frm_n_in(frm_n_in),
      .idx(idx), .phase(phase), .hf_start(hf_start));

   lcdt_hold #(.HOLD_FRAMES(HOLD_FRAMES)) u_hold (
      .clk(clk), .init(init), .hf_start(hf_start), .done(done));

   assign frm_n_out = !(master && idx == '0);
   assign lvl1      = lvl1_of(phase);
   assign lvl2      = lvl2_start(phase) ^ idx[0];
   assign blank_n   = disp_off_n && done;

   // a frame pulse opens together with a strobe high phase
   p_frm_with_stb_r2: assert property (@(posedge clk) disable iff (init)
      (master && $past(master) && $fell(frm_n_out)) |-> stb_out);
   // lvl2 flips whenever the index steps within a half frame
   p_lvl2_toggle_r3: assert property (@(posedge clk) disable iff (init)
      (idx != $past(idx) && idx != '0) |-> (lvl2 != $past(lvl2)));
   p_slave_quiet_r5: assert property (@(posedge clk) disable iff (init)
      !master |-> (!stb_out && frm_n_out));
   // the hold only ends on a half-frame boundary
   p_hold_end_r7: assert property (@(posedge clk) disable iff (init)
      $rose(done) |-> $past(hf_start));
endmodule

// File: tb/lcd_frame_timer_test.sv
module lcd_frame_timer_test;
   localparam int CPS  = 4;
   localparam int SPH  = 5;
   localparam int HOLD = 2;
   localparam int HF   = CPS * SPH;

   logic clk = 1'b0;
   logic rst_n = 1'b0, refresh_n = 1'b1, master = 1'b1;
   logic stb_in = 1'b0, frm_n_in = 1'b1, disp_off_n = 1'b1;
   logic stb_out, frm_n_out, lvl1, lvl2, blank_n;

   int vectors = 0;
   int fails   = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   lcd_frame_timer #(.CLK_PER_STB(CPS), .STB_PER_HALF(SPH), .HOLD_FRAMES(HOLD)) uut (
      .clk(clk), .rst_n(rst_n), .refresh_n(refresh_n), .master(master),
      .stb_in(stb_in), .frm_n_in(frm_n_in), .disp_off_n(disp_off_n),
      .stb_out(stb_out), .frm_n_out(frm_n_out), .lvl1(lvl1), .lvl2(lvl2),
      .blank_n(blank_n));

   task automatic chk(input string tag, input logic act, input logic exp);
      vectors++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%b expected=%b time=%0t", tag, act, exp, $time);
      end
   endtask

   function automatic logic e_lvl1(input int ph);
      return (ph % 4) < 2;
   endfunction
   function automatic logic e_lvl2(input int ph, input int ix);
      logic s;
      case (ph % 4)
         0: s = 1'b1;
         1: s = 1'b0;
         2: s = 1'b0;
         default: s = 1'b1;
      endcase
      return s ^ ix[0];
   endfunction

   task automatic check_init(input logic m);
      chk("R9 stb", stb_out, m);
      chk("R9 frm", frm_n_out, !m);
      chk("R9 lvl1", lvl1, 1'b1);
      chk("R9 lvl2", lvl2, 1'b1);
      chk("R9 blank", blank_n, 1'b0);
   endtask

   // master sweep; t counts edges since release
   task automatic master_sweep(input int n, input int off_lo, input int off_hi);
      for (int t = 1; t <= n; t++) begin
         int cc, ix, ph;
         logic exp_blank;
         @(posedge clk);
         @(negedge clk);
         disp_off_n = !(t >= off_lo && t < off_hi);
         #1;
         cc = t % CPS;
         ix = (t / CPS) % SPH;
         ph = t / HF;
         exp_blank = disp_off_n && (ph >= 2 * HOLD);
         chk("R1 stb", stb_out, cc < CPS / 2);
         chk("R2 frm", frm_n_out, ix != 0);
         chk("R4 lvl1", lvl1, e_lvl1(ph));
         chk("R3 lvl2", lvl2, e_lvl2(ph, ix));
         if (t >= off_lo && t < off_hi) chk("R8 blank", blank_n, 1'b0);
         else                          chk("R7 blank", blank_n, exp_blank);
      end
      disp_off_n = 1'b1;
   endtask

   task automatic slave_strobe(input logic f);
      @(negedge clk);
      frm_n_in = f;
      stb_in   = 1'b1;
      repeat (2) @(negedge clk);
      stb_in = 1'b0;
      repeat (2) @(negedge clk);
      frm_n_in = 1'b1;
      #1;
   endtask

   initial begin
      #400000;
      if (!finished) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end

   initial begin
      // master, reset state
      repeat (3) @(posedge clk);
      @(negedge clk);
      check_init(1'b1);
      rst_n = 1'b1;
      // R8 display-off spans the hold expiry at t=2*HOLD*HF
      master_sweep(10 * HF, 2 * HOLD * HF - 3, 2 * HOLD * HF + 5);

      // refresh restarts timing and hold
      @(negedge clk);
      refresh_n = 1'b0;
      repeat (2) @(negedge clk);
      check_init(1'b1);
      refresh_n = 1'b1;
      master_sweep(6 * HF, 0, 0);

      // slave mode
      @(negedge clk);
      rst_n  = 1'b0;
      master = 1'b0;
      repeat (2) @(negedge clk);
      check_init(1'b0);
      rst_n = 1'b1;
      // R6 strobes without a frame pulse are ignored
      for (int i = 0; i < 3; i++) begin
         slave_strobe(1'b1);
         chk("R6 lvl1", lvl1, 1'b1);
         chk("R6 lvl2", lvl2, 1'b1);
         chk("R7 slave blank", blank_n, 1'b0);
      end
      for (int k = 0; k < 8; k++) begin
         for (int s = 0; s < SPH; s++) begin
            slave_strobe(s != 0);
            chk("R5 stb quiet", stb_out, 1'b0);
            chk("R5 frm quiet", frm_n_out, 1'b1);
            chk("R5 lvl1", lvl1, e_lvl1(k));
            chk("R5 lvl2", lvl2, e_lvl2(k, s));
            chk("R7 slave blank", blank_n, k >= 2 * HOLD);
         end
      end
      // index saturates at the last strobe (phase 3, index SPH-1)
      slave_strobe(1'b1);
      chk("R5 saturate lvl2", lvl2, e_lvl2(3, SPH - 1));
      slave_strobe(1'b0);
      chk("R5 wrap lvl1", lvl1, 1'b1);
      chk("R5 wrap lvl2", lvl2, 1'b1);
      slave_strobe(1'b1);
      chk("R5 idx1 lvl2", lvl2, 1'b0);
      // early frame pulse realigns index and steps phase
      slave_strobe(1'b0);
      chk("R5 realign lvl1", lvl1, e_lvl1(1));
      chk("R5 realign lvl2", lvl2, e_lvl2(1, 0));
      disp_off_n = 1'b0;
      #1;
      chk("R8 slave blank", blank_n, 1'b0);
      disp_off_n = 1'b1;

      finished = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end
endmodule